// File: doc/BRIEF.md
# Two-Stage Sign-Magnitude Decimal Adder/Subtractor

This block adds or subtracts two signed decimal words. Each word holds a packed BCD magnitude, 11 digits by default, and a separate sign bit. The work is split over two fixed clock stages:

- **First stage.** It forms a raw sum for every digit position. When the operation is really a subtraction, it first complements the second operand digit by digit to nines. It also checks that every input digit is a legal code. It then takes a mod-9 residue of each operand.
- **Second stage.** It ripples the inter-digit carries across the whole word, including the end-around carry of a subtraction. It applies the per-digit unit correction and recomplements a negative difference. It then checks the finished result against the stored residues.

The block is fully pipelined. A new operand pair may enter on every clock, and each result appears two clocks after its operands were sampled. Each result carries an overflow flag and a check-error flag.

Top module: `dec_addsub`

## Requirements
- R1: A pair sampled with `in_valid` high at clock edge k yields `out_valid` high after edge k+2. Pairs may arrive on consecutive clocks and come out in order, one per clock. After reset, `out_valid` is low.
- R2: Digit i of a magnitude sits at bits [4i+3:4i]. A sign bit of 1 means negative. `sub_op`=1 negates the second operand before the operation. When the sign of the first operand equals the effective sign of the second, the result magnitude is the sum of the magnitudes and the result sign is the first operand's sign.
- R3: When the effective signs differ, the result magnitude is the absolute difference of the magnitudes. The result sign is the sign of the operand with the larger magnitude, using the effective sign for the second operand.
- R4: On an effective addition whose sum reaches 10^NDIG, `ovf` is set and the result keeps the low NDIG digits. An effective subtraction never sets `ovf`.
- R5: A result magnitude of zero always carries sign 0, including after overflow and after equal-magnitude subtraction.
- R6: Any operand digit code above 9 sets `chk_err` on that result.
- R7: For operands with only legal digits, `chk_err` stays low and every result digit is 0 to 9.
- R8: While `out_valid` is low, `ovf` and `chk_err` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operand pair present |
| sub_op | input | 1 | 1 = subtract second operand, 0 = add |
| a_sign | input | 1 | Sign of first operand, 1 = negative |
| a_mag | input | 4*NDIG | BCD magnitude of first operand |
| b_sign | input | 1 | Sign of second operand, 1 = negative |
| b_mag | input | 4*NDIG | BCD magnitude of second operand |
| out_valid | output | 1 | Result present |
| res_sign | output | 1 | Result sign, 1 = negative |
| res_mag | output | 4*NDIG | BCD magnitude of result |
| ovf | output | 1 | Effective-addition carry out of top digit |
| chk_err | output | 1 | Digit-code or residue check failed |

## Verification
The assertions check several structural properties on every cycle:
- the two-clock valid pipeline;
- that overflow is never raised on an effective subtraction;
- that a zero result is never negative;
- that the flags stay quiet between results;
- that result digits are legal whenever no error is flagged.

Only the bench scenarios can show the arithmetic itself. These cover the correct magnitude and sign for each sign/command combination, the end-around carry and recomplement paths, the wrap on overflow, and detection of illegal input codes. The bench compares each result against a 64-bit integer model.

// File: rtl/dec_add_pkg.sv
package dec_add_pkg;
    localparam int DIG_W = 4;
    localparam int SUM_W = 5;

    // residue modulo nine of a small value (inputs stay below 32)
    function automatic logic [3:0] mod9(input logic [4:0] x);
        return 4'(x % 5'd9);
    endfunction
endpackage

// File: rtl/dec_digit_former.sv
module dec_digit_former #(
    parameter int NDIG = 11
) (
    input  logic [4*NDIG-1:0] a_mag,
    input  logic [4*NDIG-1:0] b_mag,
    input  logic              eff_sub,
    output logic [5*NDIG-1:0] dsum,
    output logic              bad_code,
    output logic [3:0]        res_a,
    output logic [3:0]        res_b
);
    import dec_add_pkg::*;

    logic [NDIG-1:0] bad_vec;

    for (genvar i = 0; i < NDIG; i++) begin : g_dig
        logic [3:0] ad;
        logic [3:0] bd;
        logic [3:0] bx;
        assign ad = a_mag[DIG_W*i +: DIG_W];
        assign bd = b_mag[DIG_W*i +: DIG_W];
        // nines complement of the second operand on effective subtraction
        assign bx = eff_sub ? (4'd9 - bd) : bd;
        assign dsum[SUM_W*i +: SUM_W] = {1'b0, ad} + {1'b0, bx};
        assign bad_vec[i] = (ad > 4'd9) || (bd > 4'd9);
    end

    assign bad_code = |bad_vec;

    logic [3:0] acc_a;
    logic [3:0] acc_b;

    always_comb begin
        acc_a = 4'd0;
        acc_b = 4'd0;
        for (int i = 0; i < NDIG; i++) begin
            acc_a = mod9({1'b0, acc_a} + {1'b0, a_mag[DIG_W*i +: DIG_W]});
            acc_b = mod9({1'b0, acc_b} + {1'b0, b_mag[DIG_W*i +: DIG_W]});
        end
        res_a = acc_a;
        res_b = acc_b;
    end
endmodule

// File: rtl/dec_carry_unit.sv
module dec_carry_unit #(
    parameter int NDIG = 11
) (
    input  logic [5*NDIG-1:0] dsum,
    input  logic              eff_sub,
    output logic [4*NDIG-1:0] mag_raw,
    output logic              cout0
);
    import dec_add_pkg::*;

    logic [NDIG-1:0] gen;
    logic [NDIG-1:0] prop;
    logic            c;
    logic            cin;
    logic [4:0]      t;

    always_comb begin
        for (int i = 0; i < NDIG; i++) begin
            gen[i]  = dsum[SUM_W*i +: SUM_W] > 5'd9;
            prop[i] = dsum[SUM_W*i +: SUM_W] == 5'd9;
        end
        // first pass: carry out of the top digit with zero carry in
        c = 1'b0;
        for (int i = 0; i < NDIG; i++) begin
            c = gen[i] | (prop[i] & c);
        end
        cout0 = c;
        // end-around carry feeds the bottom digit on subtraction
        cin = eff_sub & cout0;
        c   = cin;
        mag_raw = '0;
        for (int i = 0; i < NDIG; i++) begin
            t = dsum[SUM_W*i +: SUM_W] + {4'd0, c};
            if (t >= 5'd10) begin
                mag_raw[DIG_W*i +: DIG_W] = 4'(t - 5'd10);
            end else begin
                mag_raw[DIG_W*i +: DIG_W] = t[3:0];
            end
            c = gen[i] | (prop[i] & c);
        end
    end
endmodule

// File: rtl/dec_result_check.sv
module dec_result_check #(
    parameter int NDIG = 11
) (
    input  logic [4*NDIG-1:0] mag,
    input  logic [3:0]        res_a,
    input  logic [3:0]        res_b,
    input  logic              eff_sub,
    input  logic              carry,
    input  logic              bad_in,
    output logic              err
);
    import dec_add_pkg::*;

    logic [3:0] res_r;
    logic       dig_bad;
    logic [3:0] lhs;
    logic [3:0] rhs;

    always_comb begin
        res_r   = 4'd0;
        dig_bad = 1'b0;
        for (int i = 0; i < NDIG; i++) begin
            res_r   = mod9({1'b0, res_r} + {1'b0, mag[DIG_W*i +: DIG_W]});
            dig_bad = dig_bad | (mag[DIG_W*i +: DIG_W] > 4'd9);
        end
        if (!eff_sub) begin
            lhs = mod9({1'b0, res_a} + {1'b0, res_b});
            rhs = mod9({1'b0, res_r} + {4'd0, carry});
        end else if (carry) begin
            lhs = res_a;
            rhs = mod9({1'b0, res_b} + {1'b0, res_r});
        end else begin
            lhs = res_b;
            rhs = mod9({1'b0, res_a} + {1'b0, res_r});
        end
        err = bad_in | dig_bad | (lhs != rhs);
    end
endmodule

// File: rtl/dec_addsub.sv
module dec_addsub #(
    parameter int NDIG = 11
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic              sub_op,
    input  logic              a_sign,
    input  logic [4*NDIG-1:0] a_mag,
    input  logic              b_sign,
    input  logic [4*NDIG-1:0] b_mag,
    output logic              out_valid,
    output logic              res_sign,
    output logic [4*NDIG-1:0] res_mag,
    output logic              ovf,
    output logic              chk_err
);
    import dec_add_pkg::*;

    localparam int MW  = DIG_W * NDIG;
    localparam int SVW = SUM_W * NDIG;

    typedef struct packed {
        logic           valid;
        logic           eff_sub;
        logic           sign_a;
        logic           sign_b;
        logic [SVW-1:0] dsum;
        logic [3:0]     ra;
        logic [3:0]     rb;
        logic           bad;
    } ph1_t;

    typedef struct packed {
        logic          valid;
        logic          sign;
        logic [MW-1:0] mag;
        logic          ovf;
        logic          err;
    } ph2_t;

    ph1_t ph1_d, ph1_q;
    ph2_t ph2_d, ph2_q;

    logic           eff_sub_in;
    logic [SVW-1:0] dsum_w;
    logic           bad_w;
    logic [3:0]     ra_w;
    logic [3:0]     rb_w;
    logic [MW-1:0]  raw_w;
    logic           cout_w;
    logic [MW-1:0]  fin_mag;
    logic           err_w;
    logic           recomp;

    assign eff_sub_in = a_sign ^ b_sign ^ sub_op;

    dec_digit_former #(.NDIG(NDIG)) u_former (
        .a_mag    (a_mag),
        .b_mag    (b_mag),
        .eff_sub  (eff_sub_in),
        .dsum     (dsum_w),
        .bad_code (bad_w),
        .res_a    (ra_w),
        .res_b    (rb_w)
    );

    dec_carry_unit #(.NDIG(NDIG)) u_carry (
        .dsum    (ph1_q.dsum),
        .eff_sub (ph1_q.eff_sub),
        .mag_raw (raw_w),
        .cout0   (cout_w)
    );

    dec_result_check #(.NDIG(NDIG)) u_check (
        .mag     (fin_mag),
        .res_a   (ph1_q.ra),
        .res_b   (ph1_q.rb),
        .eff_sub (ph1_q.eff_sub),
        .carry   (cout_w),
        .bad_in  (ph1_q.bad),
        .err     (err_w)
    );

    always_comb begin
        // stage one capture
        ph1_d.valid   = in_valid;
        ph1_d.eff_sub = eff_sub_in;
        ph1_d.sign_a  = a_sign;
        ph1_d.sign_b  = b_sign ^ sub_op;
        ph1_d.dsum    = dsum_w;
        ph1_d.ra      = ra_w;
        ph1_d.rb      = rb_w;
        ph1_d.bad     = bad_w;

        // stage two: recomplement a negative difference
        recomp = ph1_q.eff_sub & ~cout_w;
        for (int i = 0; i < NDIG; i++) begin
            fin_mag[DIG_W*i +: DIG_W] = recomp ? (4'd9 - raw_w[DIG_W*i +: DIG_W])
                                               : raw_w[DIG_W*i +: DIG_W];
        end

        ph2_d = '0;
        if (ph1_q.valid) begin
            ph2_d.valid = 1'b1;
            ph2_d.mag   = fin_mag;
            ph2_d.ovf   = ~ph1_q.eff_sub & cout_w;
            ph2_d.err   = err_w;
            if (fin_mag == '0) begin
                ph2_d.sign = 1'b0;
            end else if (ph1_q.eff_sub && !cout_w) begin
                ph2_d.sign = ph1_q.sign_b;
            end else begin
                ph2_d.sign = ph1_q.sign_a;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ph1_q <= '0;
            ph2_q <= '0;
        end else begin
            ph1_q <= ph1_d;
            ph2_q <= ph2_d;
        end
    end

    assign out_valid = ph2_q.valid;
    assign res_sign  = ph2_q.sign;
    assign res_mag   = ph2_q.mag;
    assign ovf       = ph2_q.ovf;
    assign chk_err   = ph2_q.err;
endmodule

// File: rtl/dec_addsub_chk.sv
module dec_addsub_chk #(
    parameter int NDIG = 11
) (
    input logic              clk,
    input logic              rst_n,
    input logic              in_valid,
    input logic              sub_op,
    input logic              a_sign,
    input logic              b_sign,
    input logic              out_valid,
    input logic              res_sign,
    input logic [4*NDIG-1:0] res_mag,
    input logic              ovf,
    input logic              chk_err
);
    logic v1_q, v2_q, s1_q, s2_q;
    logic dig_ok;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            v1_q <= 1'b0;
            v2_q <= 1'b0;
            s1_q <= 1'b0;
            s2_q <= 1'b0;
        end else begin
            v1_q <= in_valid;
            v2_q <= v1_q;
            s1_q <= a_sign ^ b_sign ^ sub_op;
            s2_q <= s1_q;
        end
    end

    always_comb begin
        dig_ok = 1'b1;
        for (int i = 0; i < NDIG; i++) begin
            if (res_mag[4*i +: 4] > 4'd9) dig_ok = 1'b0;
        end
    end

    p_latency_r1: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid == v2_q);

    p_no_overflow_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && ovf) |-> !s2_q);

    p_zero_positive_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && res_mag == '0) |-> !res_sign);

    p_digits_legal_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !chk_err) |-> dig_ok);

    p_quiet_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> (!ovf && !chk_err));
endmodule

bind dec_addsub dec_addsub_chk #(.NDIG(NDIG)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .sub_op    (sub_op),
    .a_sign    (a_sign),
    .b_sign    (b_sign),
    .out_valid (out_valid),
    .res_sign  (res_sign),
    .res_mag   (res_mag),
    .ovf       (ovf),
    .chk_err   (chk_err)
);

// File: tb/dec_addsub_tb_top.sv
`timescale 1ns/1ps
module dec_addsub_tb_top;
    localparam int    N   = 11;
    localparam int    MW  = 4*N;
    localparam longint LIM = 64'd100000000000;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          in_valid, sub_op, a_sign, b_sign;
    logic [MW-1:0] a_mag, b_mag;
    logic          out_valid, res_sign, ovf, chk_err;
    logic [MW-1:0] res_mag;

    always #10 clk = ~clk;

    dec_addsub #(.NDIG(N)) dut_i (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .sub_op(sub_op),
        .a_sign(a_sign), .a_mag(a_mag), .b_sign(b_sign), .b_mag(b_mag),
        .out_valid(out_valid), .res_sign(res_sign), .res_mag(res_mag),
        .ovf(ovf), .chk_err(chk_err)
    );

    typedef struct {
        longint        stamp;
        bit            sign;
        logic [MW-1:0] mag;
        bit            ovf;
        bit            only_err;
        string         req;
    } exp_t;

    exp_t   sb_q[$];
    int     total = 0;
    int     bad   = 0;
    longint cyc   = 0;
    bit     mon_on = 0;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input bit ok, input string req, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic longint bcd2int(input logic [MW-1:0] m);
        longint r = 0;
        for (int i = N-1; i >= 0; i--) r = r*10 + longint'(m[4*i +: 4]);
        return r;
    endfunction

    function automatic logic [MW-1:0] int2bcd(input longint v);
        logic [MW-1:0] m = '0;
        longint x = v;
        for (int i = 0; i < N; i++) begin
            m[4*i +: 4] = 4'(x % 10);
            x = x / 10;
        end
        return m;
    endfunction

    task automatic send(input bit as, input longint av, input bit bs,
                        input longint bv, input bit sub, input string req);
        exp_t e;
        longint sa, sbv, r, ar;
        bit bn;
        @(negedge clk);
        in_valid = 1; sub_op = sub; a_sign = as; b_sign = bs;
        a_mag = int2bcd(av); b_mag = int2bcd(bv);
        bn  = bs ^ sub;
        sa  = as ? -av : av;
        sbv = bn ? -bv : bv;
        r   = sa + sbv;
        ar  = (r < 0) ? -r : r;
        e.stamp    = cyc;
        e.ovf      = (as == bn) && (ar >= LIM);
        e.mag      = int2bcd(ar % LIM);
        e.sign     = (r < 0) && ((ar % LIM) != 0);
        e.only_err = 0;
        e.req      = req;
        sb_q.push_back(e);
    endtask

    task automatic send_raw(input logic [MW-1:0] am, input logic [MW-1:0] bm);
        exp_t e;
        @(negedge clk);
        in_valid = 1; sub_op = 0; a_sign = 0; b_sign = 0;
        a_mag = am; b_mag = bm;
        e.stamp = cyc; e.sign = 0; e.mag = '0; e.ovf = 0;
        e.only_err = 1; e.req = "R6";
        sb_q.push_back(e);
    endtask

    task automatic idle();
        @(negedge clk);
        in_valid = 0;
    endtask

    function automatic longint rnd_val(input bit high);
        longint v = 0;
        for (int i = 0; i < N; i++) begin
            v = v*10 + (high ? longint'($urandom_range(5, 9)) : longint'($urandom_range(0, 9)));
        end
        return v;
    endfunction

    // monitor / scoreboard
    always @(negedge clk) begin
        if (mon_on) begin
            if (out_valid) begin
                if (sb_q.size() == 0) begin
                    check(0, "R1", "unexpected result", 1, 0);
                end else begin
                    exp_t e;
                    e = sb_q.pop_front();
                    check(cyc == e.stamp + 2, "R1", "latency", cyc - e.stamp, 2);
                    if (e.only_err) begin
                        check(chk_err == 1'b1, e.req, "chk_err", chk_err, 1);
                    end else begin
                        check(res_mag == e.mag, e.req, "magnitude", res_mag, e.mag);
                        check(res_sign == e.sign, e.req, "sign", res_sign, e.sign);
                        check(ovf == e.ovf, "R4", "ovf", ovf, e.ovf);
                        check(chk_err == 1'b0, "R7", "chk_err", chk_err, 0);
                    end
                end
            end else begin
                check(!ovf && !chk_err, "R8", "idle flags", {ovf, chk_err}, 0);
            end
        end
    end

    longint nines;

    initial begin
        rst_n = 0; in_valid = 0; sub_op = 0; a_sign = 0; b_sign = 0;
        a_mag = '0; b_mag = '0;
        nines = LIM - 1;
        repeat (3) @(negedge clk);
        check(out_valid == 1'b0, "R1", "reset out_valid", out_valid, 0);
        check(!ovf && !chk_err, "R8", "reset flags", {ovf, chk_err}, 0);
        rst_n = 1;
        mon_on = 1;

        send(0, 123, 0, 456, 0, "R2");
        send(1, 123, 1, 456, 0, "R2");
        send(0, 987654321, 1, 12345, 1, "R2");   // subtract a negative
        send(0, 500, 0, 200, 1, "R3");
        send(0, 200, 0, 500, 1, "R3");
        send(1, 800, 0, 300, 0, "R3");
        send(0, 7, 1, 7, 0, "R5");
        send(1, 5, 1, 5, 1, "R5");
        send(0, nines, 0, 1, 0, "R5");           // overflow to zero
        send(0, nines, 0, nines, 0, "R4");
        send(1, nines, 1, 3, 0, "R4");
        send(0, 0, 0, nines, 1, "R4");           // large sub, no overflow
        send(0, nines, 1, nines, 0, "R5");
        idle();
        send_raw(44'h0000000000A, '0);
        send_raw('0, 44'h0F000000000);
        send(0, 42, 0, 58, 0, "R2");
        idle();
        idle();

        for (int k = 0; k < 400; k++) begin
            bit hi = ($urandom_range(0, 3) == 0);
            bit sg = $urandom_range(0, 1) == 1;
            bit sg2 = $urandom_range(0, 1) == 1;
            bit sb2 = $urandom_range(0, 1) == 1;
            send(sg, rnd_val(hi), sg2, rnd_val(hi), sb2, (sg ^ sg2 ^ sb2) ? "R3" : "R2");
            if ($urandom_range(0, 7) == 0) idle();
        end
        repeat (5) idle();
        check(sb_q.size() == 0, "R1", "results outstanding", sb_q.size(), 0);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #(20 * 50000);
        total++;
        bad++;
        $display("FAIL R1 watchdog: actual=%0d expected=%0d", 1, 0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule